// File: doc/BRIEF.md
# Keyboard and Terminal Bus Port

This block places a keyboard and a character terminal on the bus of an 8-bit processor that has a 16-bit address. It decodes a window of four byte addresses, 0xD010 to 0xD013 by default. Keystrokes from the keyboard are folded to uppercase and held in a key register. Bit 7 of that register marks a key that the CPU has not yet read. Software reads the key register and then clears the mark by writing to a second address.

Characters written by the CPU leave on the terminal side as a single-cycle strobe with 7-bit data. The terminal's ready input can be read back as an inverted busy flag, so software can poll before it writes. Reads return data combinationally in the same cycle as the read strobe. Writes take effect at the clock edge on which the write enable is sampled.

Top module: `kbd_term_port`

## Requirements
- R1: After reset, a read of 0xD010 returns 0x00, a read of 0xD011 returns 0x00, term_valid is 0 and term_char is 0x00.
- R2: A cycle with kb_valid high latches kb_data into the key register. From the next cycle, a read of 0xD010 returns {1'b1, code[6:0]}, with bit 7 being the pending flag.
- R3: A keyboard code from 0x61 to 0x7A is stored as the code minus 0x20. Every other code, including 0x60 and 0x7B, is stored unchanged.
- R4: A keystroke that arrives while one is pending replaces the stored code, and the pending flag stays set.
- R5: A write of any value to 0xD011 clears the pending flag from the next cycle. Bits 6:0 of the key register are left unchanged.
- R6: When kb_valid and a write to 0xD011 occur in the same cycle, the keystroke wins: the new code is stored and the pending flag is set.
- R7: A read of 0xD011 returns the pending flag in bit 7 and zero in bits 6:0.
- R8: A write to 0xD012 raises term_valid for exactly the next cycle, with term_char equal to the written byte with bit 7 forced to 0. This happens whatever the state of term_ready.
- R9: A read of 0xD012 returns bit 7 equal to the inverse of term_ready in the same cycle, and zero in bits 6:0.
- R10: A read of 0xD013, or of any address outside the window, returns 0x00. A write to 0xD013, or to any address outside the window, changes neither the key register nor the terminal outputs.
- R11: bus_rdata is 0x00 whenever bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_we | input | 1 | Write enable, sampled at the clock edge |
| bus_re | input | 1 | Read strobe, gates bus_rdata |
| bus_rdata | output | 8 | Read data, combinational |
| kb_valid | input | 1 | Keyboard code valid for one cycle |
| kb_data | input | 7 | Keyboard ASCII code |
| term_valid | output | 1 | One-cycle character strobe to the terminal |
| term_char | output | 8 | Character to the terminal, bit 7 always 0 |
| term_ready | input | 1 | Terminal can accept a character |

## Verification
The assertions assume that bus_we and bus_re are never high in the same cycle. They also assume that the window base has its two low address bits at zero. The bench drives every bus access as either a write or a read, never both, and keeps the default base. All inputs change at the falling clock edge, so kb_valid, the write strobes and term_ready stay steady across each sampling edge. The checks count registers from the edge on which a write or keystroke is captured.

// File: rtl/kbd_term_port.sv
module kbd_term_port #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hD010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  input  logic              kb_valid,
  input  logic [6:0]        kb_data,
  output logic              term_valid,
  output logic [7:0]        term_char,
  input  logic              term_ready
);

  localparam logic [ADDR_W-3:0] WIN = BASE[ADDR_W-1:2];
  localparam logic [1:0] SEL_KEY  = 2'd0;
  localparam logic [1:0] SEL_CLR  = 2'd1;
  localparam logic [1:0] SEL_TERM = 2'd2;

  wire       in_win  = (bus_addr[ADDR_W-1:2] == WIN);
  wire [1:0] sel     = bus_addr[1:0];
  wire       wr_clr  = bus_we && in_win && (sel == SEL_CLR);
  wire       wr_term = bus_we && in_win && (sel == SEL_TERM);

  wire       is_lower  = (kb_data >= 7'h61) && (kb_data <= 7'h7A);
  wire [6:0] kb_folded = is_lower ? kb_data - 7'h20 : kb_data;

  logic [6:0] key_code;
  logic       key_pend;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      key_code <= '0;
      key_pend <= 1'b0;
    end else if (kb_valid) begin
      key_code <= kb_folded;
      key_pend <= 1'b1;
    end else if (wr_clr) begin
      key_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      term_valid <= 1'b0;
      term_char  <= '0;
    end else begin
      term_valid <= wr_term;
      if (wr_term) term_char <= bus_wdata & 8'h7F;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re && in_win) begin
      case (sel)
        SEL_KEY:  bus_rdata = {key_pend, key_code};
        SEL_CLR:  bus_rdata = {key_pend, 7'b0};
        SEL_TERM: bus_rdata = {~term_ready, 7'b0};
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R2
  key_latch_chk: assert property (@(posedge clk) disable iff (rst)
    kb_valid |=> key_pend);

  // R3
  key_fold_chk: assert property (@(posedge clk) disable iff (rst)
    kb_valid |=> !((key_code >= 7'h61) && (key_code <= 7'h7A)));

  // R5
  key_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !kb_valid) |=> (!key_pend && $stable(key_code)));

  // R8
  term_send_chk: assert property (@(posedge clk) disable iff (rst)
    wr_term |=> (term_valid && term_char == {1'b0, $past(bus_wdata[6:0])}));

  // R8
  term_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_term |=> !term_valid);

  // R10
  reg3_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == BASE + 3) |-> bus_rdata == 8'h00);

  // R11
  idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |-> bus_rdata == 8'h00);

endmodule

// File: tb/kbd_term_port_tb_top.sv
`timescale 1ns/1ps
module kbd_term_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic        kb_valid = 1'b0;
  logic [6:0]  kb_data = '0;
  logic        term_valid;
  logic [7:0]  term_char;
  logic        term_ready = 1'b1;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  kbd_term_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .kb_valid(kb_valid), .kb_data(kb_data), .term_valid(term_valid),
    .term_char(term_char), .term_ready(term_ready)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic key(input logic [6:0] c);
    kb_valid = 1'b1; kb_data = c;
    step();
    kb_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(16'hD010, d); check("R1 key reg", d, 8'h00);
    rd(16'hD011, d); check("R1 status", d, 8'h00);
    check("R1 term_valid", {7'b0, term_valid}, 8'h00);
    check("R1 term_char", term_char, 8'h00);
  endtask

  task automatic t_latch_fold;
    logic [7:0] d;
    key(7'h41); rd(16'hD010, d); check("R2 latch A", d, 8'hC1);
    rd(16'hD011, d); check("R7 pending", d, 8'h80);
    key(7'h61); rd(16'hD010, d); check("R3 fold a", d, 8'hC1);
    key(7'h7A); rd(16'hD010, d); check("R3 fold z", d, 8'hDA);
    key(7'h60); rd(16'hD010, d); check("R3 0x60 kept", d, 8'hE0);
    key(7'h7B); rd(16'hD010, d); check("R3 0x7B kept", d, 8'hFB);
  endtask

  task automatic t_overwrite_clear;
    logic [7:0] d;
    key(7'h31); key(7'h32); rd(16'hD010, d); check("R4 overwrite", d, 8'hB2);
    wr(16'hD011, 8'h5A); rd(16'hD010, d); check("R5 clear", d, 8'h32);
    rd(16'hD011, d); check("R7 cleared", d, 8'h00);
    bus_addr = 16'hD011; bus_wdata = 8'h00; bus_we = 1'b1;
    kb_valid = 1'b1; kb_data = 7'h39;
    step();
    bus_we = 1'b0; kb_valid = 1'b0;
    rd(16'hD010, d); check("R6 key wins", d, 8'hB9);
  endtask

  task automatic t_term;
    logic [7:0] d;
    term_ready = 1'b1;
    rd(16'hD012, d); check("R9 ready", d, 8'h00);
    term_ready = 1'b0;
    rd(16'hD012, d); check("R9 busy", d, 8'h80);
    wr(16'hD012, 8'hC8);
    check("R8 strobe", {7'b0, term_valid}, 8'h01);
    check("R8 char masked", term_char, 8'h48);
    step();
    check("R8 one cycle", {7'b0, term_valid}, 8'h00);
    term_ready = 1'b1;
    wr(16'hD012, 8'h0D);
    check("R8 char CR", term_char, 8'h0D);
  endtask

  task automatic t_outside;
    logic [7:0] d;
    key(7'h44);
    wr(16'hD013, 8'hFF);
    check("R10 D013 no strobe", {7'b0, term_valid}, 8'h00);
    wr(16'hC011, 8'h00); wr(16'hD111, 8'h00); wr(16'h0012, 8'h41);
    check("R10 outside no strobe", {7'b0, term_valid}, 8'h00);
    rd(16'hD010, d); check("R10 key kept", d, 8'hC4);
    rd(16'hD013, d); check("R10 D013 zero", d, 8'h00);
    rd(16'hD014, d); check("R10 D014 zero", d, 8'h00);
    rd(16'hD00F, d); check("R10 D00F zero", d, 8'h00);
    bus_addr = 16'hD010; #1;
    check("R11 no read strobe", bus_rdata, 8'h00);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_latch_fold();
    t_overwrite_clear();
    t_term();
    t_outside();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule